// File: doc/BRIEF.md
# Nibble-Wide Asynchronous DRAM Controller with CAS-before-RAS Refresh

This block sits between a simple host port and a small asynchronous DRAM that stores 4-bit words behind an 8-bit multiplexed address bus. The host raises a request carrying an 11-bit nibble address, a direction bit and, for writes, a data nibble. The controller splits the address into a row and a column, drives the active-low row strobe, column strobe, output enable and write enable in a fixed order, and reports completion with a one-cycle done pulse. Reads also return the nibble on a host read-data output. Every step between strobe edges lasts a fixed, parameterised number of clock cycles. An all-high idle gap separates any operation from the next one.

A free-running interval timer requests a refresh burst once per refresh period. The default period is derived from the clock frequency and a 4 ms target. A burst is a run of CAS-before-RAS cycles, one per row. A burst never splits a host access: it starts only from idle. When a refresh and a host request are waiting together, the refresh goes first and the host request stays pending until the burst is over. The controller drives the data bus only while a write is in progress.

Top module: `dram_nibble_ctrl`

## Requirements
- R1: During an access, the value on `mem_addr` when `mem_ras_n` falls is the host address shifted right by 3 (row). The value when `mem_cas_n` falls is the host address bits [2:0], zero-extended (column).
- R2: A read lowers `mem_ras_n`, then `mem_cas_n`, then `mem_oe_n`. It raises `mem_oe_n` while both strobes are still low, and then raises `mem_cas_n` and `mem_ras_n` in the same cycle.
- R3: A read returns the nibble presented on `mem_dq_in` while `mem_oe_n` is low on `host_rdata`, together with `host_done` high for exactly one cycle.
- R4: A write drives the row address and the data when `mem_ras_n` falls. It lowers `mem_we_n` after `mem_ras_n` and before `mem_cas_n`, and keeps the data on `mem_dq_out` when `mem_cas_n` falls. It then raises `mem_we_n`, raises `mem_cas_n` and `mem_ras_n` together, and pulses `host_done` for one cycle.
- R5: `mem_dq_oe` is high only during a write. It is low while idle, during refresh, and whenever `mem_oe_n` is low.
- R6: A refresh burst consists of REF_ROWS cycles. In each cycle `mem_cas_n` falls, then `mem_ras_n` falls, then `mem_cas_n` rises, then `mem_ras_n` rises. Consecutive cycles start 4*T_STEP clocks apart.
- R7: When the controller stays idle, refresh bursts start exactly REF_PERIOD_CYC clocks apart. A pending refresh request is kept until a burst starts.
- R8: No refresh cycle starts between the row-strobe fall and the row-strobe rise of a host access.
- R9: When a refresh is pending as a host request is waiting in idle, the refresh burst runs first. `host_busy` stays high throughout the burst.
- R10: Each strobe step lasts T_STEP cycles. The row strobe falls 2*T_STEP cycles before the column strobe on a read, and 3*T_STEP cycles before it on a write.
- R11: After reset, all four strobes are high, `mem_dq_oe` is low, and `host_busy` and `host_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 11 | Nibble address 0x000..0x7FF |
| host_wdata | input | 4 | Write nibble |
| host_rdata | output | 4 | Read nibble, valid with done |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Controller is not idle |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 4 | Data driven toward DRAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 4 | Data returned from DRAM |

## Verification
The bench targets the extreme addresses 0x000 and 0x7FF and a row/column pattern with mixed bits. A wrong shift or mask there stores the data in the wrong cell and reads back a different nibble. It places a read so that the refresh timer expires mid-access and then issues a write straight after. A controller that preempts the access shows a CBR cycle inside the row strobe window, and one that lets the host win shows the write's row strobe before the burst. It measures the spacing between bursts and the number of cycles in each burst, which catches timers that drift by one and bursts that stop early or run long. Strobe-order checks catch output enable overlapping with a driven data bus, and a column strobe that is released before the row strobe.

// File: rtl/dnc_pkg.sv
package dnc_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_RD_ROW, S_RD_RAS, S_RD_COL, S_RD_CAS, S_RD_OE, S_RD_OEOFF,
    S_WR_ROW, S_WR_RAS, S_WR_WE, S_WR_COL, S_WR_CAS, S_WR_WEOFF,
    S_END, S_GAP,
    S_RF_CAS, S_RF_RAS, S_RF_CASOFF, S_RF_RASOFF
  } dnc_state_e;

endpackage

// File: rtl/dnc_ref_timer.sv
module dnc_ref_timer #(
  parameter int PERIOD_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;

  logic [CW-1:0] tick_cnt;
  logic          wrap;

  assign wrap = (tick_cnt == CW'(PERIOD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (wrap) begin
      tick_cnt <= '0;
    end else begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pend <= 1'b0;
    end else if (wrap) begin
      ref_pend <= 1'b1;
    end else if (ref_ack) begin
      ref_pend <= 1'b0;
    end
  end

  // an unserved refresh request must not vanish
  p_pend_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_ack) |=> ref_pend);

endmodule

// File: rtl/dnc_sequencer.sv
module dnc_sequencer
  import dnc_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 4,
  parameter int BUS_W    = 8,
  parameter int COL_W    = 3,
  parameter int REF_ROWS = 256,
  parameter int T_STEP   = 3,
  parameter int T_IDLE   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ref_pend,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ref_ack,
  output dnc_state_e        state,
  output logic [BUS_W-1:0]  row_q,
  output logic [BUS_W-1:0]  col_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q,
  output logic              busy,
  output logic              ref_active
);
  localparam int TMAX = (T_STEP > T_IDLE) ? T_STEP : T_IDLE;
  localparam int DW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(REF_ROWS + 1);

  function automatic logic [BUS_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return BUS_W'(a >> COL_W);
  endfunction

  function automatic logic [BUS_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return BUS_W'(a[COL_W-1:0]);
  endfunction

  function automatic logic [DW-1:0] dur_of(input dnc_state_e s);
    return (s == S_GAP) ? DW'(T_IDLE - 1) : DW'(T_STEP - 1);
  endfunction

  function automatic dnc_state_e step_after(input dnc_state_e s, input logic last_row);
    case (s)
      S_RD_ROW:    return S_RD_RAS;
      S_RD_RAS:    return S_RD_COL;
      S_RD_COL:    return S_RD_CAS;
      S_RD_CAS:    return S_RD_OE;
      S_RD_OE:     return S_RD_OEOFF;
      S_RD_OEOFF:  return S_END;
      S_WR_ROW:    return S_WR_RAS;
      S_WR_RAS:    return S_WR_WE;
      S_WR_WE:     return S_WR_COL;
      S_WR_COL:    return S_WR_CAS;
      S_WR_CAS:    return S_WR_WEOFF;
      S_WR_WEOFF:  return S_END;
      S_END:       return S_GAP;
      S_RF_CAS:    return S_RF_RAS;
      S_RF_RAS:    return S_RF_CASOFF;
      S_RF_CASOFF: return S_RF_RASOFF;
      S_RF_RASOFF: return last_row ? S_GAP : S_RF_CAS;
      default:     return S_IDLE;
    endcase
  endfunction

  logic [DW-1:0] step_cnt;
  logic [RW-1:0] rows_left;
  logic          step_last;
  logic          accept;
  dnc_state_e    nxt;

  assign step_last  = (step_cnt == '0);
  assign ref_ack    = (state == S_IDLE) && ref_pend;
  assign accept     = (state == S_IDLE) && !ref_pend && req;
  assign busy       = (state != S_IDLE);
  assign ref_active = (state == S_RF_CAS) || (state == S_RF_RAS) ||
                      (state == S_RF_CASOFF) || (state == S_RF_RASOFF);

  always_comb begin
    nxt = state;
    if (state == S_IDLE) begin
      if (ref_pend)  nxt = S_RF_CAS;
      else if (req)  nxt = wr ? S_WR_ROW : S_RD_ROW;
    end else if (step_last) begin
      nxt = step_after(state, rows_left == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step_cnt <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)      step_cnt <= dur_of(nxt);
      else if (!step_last)   step_cnt <= step_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_left <= '0;
    end else if (ref_ack) begin
      rows_left <= RW'(REF_ROWS - 1);
    end else if (state == S_RF_RASOFF && step_last && rows_left != '0) begin
      rows_left <= rows_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        row_q   <= row_of(addr);
        col_q   <= col_of(addr);
        wdata_q <= wdata;
      end
      if (state == S_RD_OE && step_last) rdata_q <= dq_in;
      done_q <= (state == S_END) && step_last;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // a burst may only begin from idle, never inside an access
  p_ref_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_active) |-> $past(state == S_IDLE));

  p_ref_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && ref_pend && req) |=> ref_active);

endmodule

// File: rtl/dnc_pins.sv
module dnc_pins
  import dnc_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int BUS_W  = 8
) (
  input  dnc_state_e        state,
  input  logic [BUS_W-1:0]  row_q,
  input  logic [BUS_W-1:0]  col_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [BUS_W-1:0]  mem_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic row_phase, col_phase, ras_low, cas_low, we_low, wr_phase;

  always_comb begin
    row_phase = 1'b0; col_phase = 1'b0; ras_low = 1'b0;
    cas_low   = 1'b0; we_low    = 1'b0; wr_phase = 1'b0;
    case (state)
      S_RD_ROW:    row_phase = 1'b1;
      S_RD_RAS:    begin row_phase = 1'b1; ras_low = 1'b1; end
      S_RD_COL:    begin col_phase = 1'b1; ras_low = 1'b1; end
      S_RD_CAS,
      S_RD_OE,
      S_RD_OEOFF:  begin col_phase = 1'b1; ras_low = 1'b1; cas_low = 1'b1; end
      S_WR_ROW:    begin row_phase = 1'b1; wr_phase = 1'b1; end
      S_WR_RAS:    begin row_phase = 1'b1; wr_phase = 1'b1; ras_low = 1'b1; end
      S_WR_WE:     begin row_phase = 1'b1; wr_phase = 1'b1; ras_low = 1'b1; we_low = 1'b1; end
      S_WR_COL:    begin col_phase = 1'b1; wr_phase = 1'b1; ras_low = 1'b1; we_low = 1'b1; end
      S_WR_CAS:    begin col_phase = 1'b1; wr_phase = 1'b1; ras_low = 1'b1; we_low = 1'b1;
                         cas_low = 1'b1; end
      S_WR_WEOFF:  begin col_phase = 1'b1; wr_phase = 1'b1; ras_low = 1'b1; cas_low = 1'b1; end
      S_RF_CAS:    cas_low = 1'b1;
      S_RF_RAS:    begin cas_low = 1'b1; ras_low = 1'b1; end
      S_RF_CASOFF: ras_low = 1'b1;
      default:     ;
    endcase
  end

  assign mem_addr = row_phase ? row_q : (col_phase ? col_q : '0);
  assign ras_n    = !ras_low;
  assign cas_n    = !cas_low;
  assign oe_n     = !(state == S_RD_OE);
  assign we_n     = !we_low;
  assign dq_oe    = wr_phase;
  assign dq_out   = wr_phase ? wdata_q : '0;

endmodule

// File: rtl/dram_nibble_ctrl.sv
module dram_nibble_ctrl
  import dnc_pkg::*;
#(
  parameter int CLK_KHZ        = 125000,
  parameter int REF_MS         = 4,
  parameter int REF_PERIOD_CYC = CLK_KHZ * REF_MS,
  parameter int REF_ROWS       = 256,
  parameter int T_STEP         = 3,
  parameter int T_IDLE         = 6,
  parameter int ADDR_W         = 11,
  parameter int DATA_W         = 4,
  parameter int BUS_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              host_busy,
  output logic [BUS_W-1:0]  mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int COL_W = ADDR_W - BUS_W;

  logic              ref_pend, ref_ack, ref_active;
  dnc_state_e        state;
  logic [BUS_W-1:0]  row_q, col_q;
  logic [DATA_W-1:0] wdata_q;

  dnc_ref_timer #(.PERIOD_CYC(REF_PERIOD_CYC)) i_timer (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  dnc_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .COL_W(COL_W),
    .REF_ROWS(REF_ROWS), .T_STEP(T_STEP), .T_IDLE(T_IDLE)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr),
    .addr(host_addr), .wdata(host_wdata), .ref_pend(ref_pend),
    .dq_in(mem_dq_in), .ref_ack(ref_ack), .state(state),
    .row_q(row_q), .col_q(col_q), .wdata_q(wdata_q),
    .rdata_q(host_rdata), .done_q(host_done), .busy(host_busy),
    .ref_active(ref_active)
  );

  dnc_pins #(.DATA_W(DATA_W), .BUS_W(BUS_W)) i_pins (
    .state(state), .row_q(row_q), .col_q(col_q), .wdata_q(wdata_q),
    .mem_addr(mem_addr), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
    .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
  );

  p_acc_ras_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cas_n) && !ref_active) |-> !mem_ras_n);

  p_release_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ras_n) && !ref_active) |-> $rose(mem_cas_n));

  p_cbr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && ref_active) |-> !mem_cas_n);

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_we_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_ras_n && mem_cas_n));

endmodule

// File: tb/test_dram_nibble_ctrl.sv
module test_dram_nibble_ctrl;
  localparam int PER  = 400;
  localparam int ROWS = 4;
  localparam int TS   = 2;
  localparam int TI   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [10:0] host_addr = '0;
  logic [3:0]  host_wdata = '0;
  logic [3:0]  host_rdata;
  logic        host_done, host_busy;
  logic [7:0]  mem_addr;
  logic        mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [3:0]  mem_dq_out, mem_dq_in;

  int checks = 0, errors = 0, cyc = 0;

  dram_nibble_ctrl #(.REF_PERIOD_CYC(PER), .REF_ROWS(ROWS), .T_STEP(TS), .T_IDLE(TI))
  i_dram_nibble_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .host_busy(host_busy), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tiny storage array standing in for the memory cells
  logic [3:0]  cells [2048];
  logic [10:0] cur_a = '0;
  assign mem_dq_in = !mem_oe_n ? cells[cur_a] : 4'h0;

  // edge monitor
  logic p_ras = 1, p_cas = 1, p_oe = 1, p_we = 1;
  logic [7:0] cap_row = 0, cap_col = 0;
  logic [3:0] cap_wdata = 0, cap_ras_data = 0;
  logic cap_wr = 0, cap_ras_drive = 0, in_access = 0;
  logic oe_ok = 0, we_ok = 0, rel_ok = 0;
  int ras_fall_cyc = 0, cas_fall_cyc = 0;
  int last_cbr = -1000, burst_start = -1000, prev_burst = -1000, rf_cnt = 0;
  int cbr_in_access = 0, first_evt = 0, oe_drive_bad = 0;
  logic watch = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_oe_n && mem_dq_oe) oe_drive_bad++;
      if (p_ras && !mem_ras_n && mem_cas_n) begin
        cap_row = mem_addr; in_access = 1; ras_fall_cyc = cyc;
        cap_ras_drive = mem_dq_oe; cap_ras_data = mem_dq_out;
        if (watch && first_evt == 0) first_evt = 2;
      end
      if (p_cas && !mem_cas_n && mem_ras_n) begin
        if (in_access) cbr_in_access++;
        if (cyc - last_cbr > 4*TS + 1) begin
          prev_burst = burst_start; burst_start = cyc; rf_cnt = 0;
        end
        rf_cnt++; last_cbr = cyc;
        if (watch && first_evt == 0) first_evt = 1;
      end
      if (p_cas && !mem_cas_n && !mem_ras_n) begin
        cap_col = mem_addr; cas_fall_cyc = cyc; cap_wr = !mem_we_n;
        cur_a = {cap_row, mem_addr[2:0]};
        cap_wdata = mem_dq_out;
        if (!mem_we_n) cells[cur_a] = mem_dq_out;
      end
      if (p_oe && !mem_oe_n) oe_ok = !mem_ras_n && !mem_cas_n && !mem_dq_oe;
      if (p_we && !mem_we_n) we_ok = !mem_ras_n && mem_cas_n;
      if (!p_ras && mem_ras_n && in_access) begin
        rel_ok = !p_cas && mem_cas_n; in_access = 0;
      end
    end
    p_ras = mem_ras_n; p_cas = mem_cas_n; p_oe = mem_oe_n; p_we = mem_we_n;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  int busy_gap_bad = 0;

  task automatic do_op(input logic w, input logic [10:0] a, input logic [3:0] d,
                       output logic [3:0] rd, output bit got);
    tick();
    host_req = 1; host_wr = w; host_addr = a; host_wdata = d; got = 0;
    for (int n = 0; n < 3000; n++) begin
      tick();
      if (cyc - last_cbr < 4*TS && !host_busy) busy_gap_bad++;
      if (host_done) begin got = 1; break; end
    end
    rd = host_rdata;
    host_req = 0;
  endtask

  // {wr, addr, wdata, expected read}
  localparam logic [19:0] VEC [10] = '{
    {1'b1, 11'h123, 4'h8, 4'h0}, {1'b1, 11'h7FF, 4'hF, 4'h0},
    {1'b1, 11'h000, 4'h5, 4'h0}, {1'b1, 11'h062, 4'hA, 4'h0},
    {1'b1, 11'h07A, 4'h3, 4'h0}, {1'b0, 11'h123, 4'h0, 4'h8},
    {1'b0, 11'h7FF, 4'h0, 4'hF}, {1'b0, 11'h000, 4'h0, 4'h5},
    {1'b0, 11'h062, 4'h0, 4'hA}, {1'b0, 11'h07A, 4'h0, 4'h3}
  };

  initial begin
    for (int i = 0; i < 2048; i++) cells[i] = 4'h0;
  end

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected below 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [3:0] rd;
    bit got;
    int s;
    repeat (3) tick();
    // R11 reset state while held and just after release
    chk(mem_ras_n && mem_cas_n && mem_oe_n && mem_we_n, "R11 strobes in reset",
        {mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n}, 4'hF);
    rst_n = 1;
    tick(); tick();
    chk(mem_ras_n && mem_cas_n && mem_oe_n && mem_we_n, "R11 strobes after reset",
        {mem_ras_n, mem_cas_n, mem_oe_n, mem_we_n}, 4'hF);
    chk(!mem_dq_oe && !host_busy && !host_done, "R11/R5 idle outputs",
        {mem_dq_oe, host_busy, host_done}, 0);

    // vector table
    for (int v = 0; v < 10; v++) begin
      logic        w;
      logic [10:0] a;
      logic [3:0]  d, e;
      {w, a, d, e} = VEC[v];
      do_op(w, a, d, rd, got);
      chk(got, "R3/R4 done seen", got, 1);
      chk(cap_row == 8'(a >> 3), "R1 row address", cap_row, a >> 3);
      chk(cap_col == {5'd0, a[2:0]}, "R1 column address", cap_col, a[2:0]);
      chk(rel_ok, "R2/R4 CAS and RAS released together", rel_ok, 1);
      if (w) begin
        chk(cap_wr, "R4 WE low at CAS fall", cap_wr, 1);
        chk(cap_wdata == d, "R4 data at CAS fall", cap_wdata, d);
        chk(cap_ras_drive && cap_ras_data == d, "R4 R5 data driven at RAS fall",
            {cap_ras_drive, cap_ras_data}, {1'b1, d});
        chk(we_ok, "R4 WE between RAS and CAS", we_ok, 1);
        chk(cas_fall_cyc - ras_fall_cyc == 3*TS, "R10 write RAS-to-CAS",
            cas_fall_cyc - ras_fall_cyc, 3*TS);
      end else begin
        chk(rd == e, "R3 read data", rd, e);
        chk(!cap_wr, "R2 WE high on read", cap_wr, 0);
        chk(oe_ok, "R2 R5 OE after CAS, bus released", oe_ok, 1);
        chk(cas_fall_cyc - ras_fall_cyc == 2*TS, "R10 read RAS-to-CAS",
            cas_fall_cyc - ras_fall_cyc, 2*TS);
      end
      tick();
      chk(!host_done, "R3 done one cycle", host_done, 0);
    end
    chk(!mem_dq_oe, "R5 bus released after ops", mem_dq_oe, 0);

    // R7 / R6: three bursts while idle
    for (int b = 0; b < 3; b++) begin
      s = burst_start;
      for (int n = 0; n < 2000 && burst_start == s; n++) tick();
    end
    chk(burst_start - prev_burst == PER, "R7 idle burst interval",
        burst_start - prev_burst, PER);
    repeat (4*TS*ROWS + 10) tick();
    chk(rf_cnt == ROWS, "R6 cycles per burst", rf_cnt, ROWS);
    chk(mem_ras_n && mem_cas_n && !mem_dq_oe, "R5 R6 idle after burst",
        {mem_ras_n, mem_cas_n, mem_dq_oe}, 3'b110);

    // R8 / R9: timer expires inside a read, write queued behind it
    s = burst_start;
    while (cyc < s + PER - 12) tick();
    do_op(1'b0, 11'h2C5, 4'h0, rd, got);
    chk(got, "R8 access finished", got, 1);
    watch = 1; first_evt = 0;
    do_op(1'b1, 11'h4B1, 4'h6, rd, got);
    chk(got, "R9 queued write finished", got, 1);
    chk(first_evt == 1, "R9 refresh ahead of host", first_evt, 1);
    chk(burst_start != s, "R8 burst deferred not dropped", burst_start != s, 1);
    chk(cbr_in_access == 0, "R8 no refresh inside access", cbr_in_access, 0);
    chk(busy_gap_bad == 0, "R9 busy held during burst", busy_gap_bad, 0);
    watch = 0;
    do_op(1'b0, 11'h4B1, 4'h0, rd, got);
    chk(rd == 4'h6, "R3 readback after refresh", rd, 6);
    chk(oe_drive_bad == 0, "R5 no drive while OE low", oe_drive_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule